// File: doc/BRIEF.md
# Interrupt Acceptance and Nesting Logic

This block sits in the exception unit of a processor core. An external interrupt controller offers it a request bundle each cycle: a valid bit, a non-maskable flag, a 6-bit priority level, a shadow register set number and a handler address. The block decides in the same cycle whether the request is taken, using its own status state. On the next clock edge it updates that status. On the same edge it saves the previous status into a single-entry saved-status register, so that an exception return can restore it.

The status consists of a maskable-interrupt enable, the current level, the current register set and a register-set interrupt enable. These are held in a control register that software can write. Next to it, a two-state context machine tracks whether a non-maskable handler is in progress. The machine has two states. `CTX_NORMAL` means no non-maskable handler is running. `CTX_NMI` means one is. It has three transitions. `T_TAKE_NMI` goes from `CTX_NORMAL` to `CTX_NMI` when a non-maskable request is taken. `T_RETURN` happens on an exception return: the state reloads from the saved non-maskable bit, which normally moves `CTX_NMI` back to `CTX_NORMAL`. `T_HOLD` keeps the current state in every other cycle.

A configuration input selects auto-nesting. When it is set, taking an interrupt leaves maskable interrupts enabled, so a request of higher level can preempt the running handler without software action.

Top module: `irq_accept_unit`

## Requirements
- R1: A request with `req_nmi`=1 and `req_valid`=1 is taken whenever `sts_nmi` is 0, regardless of the enable, level and register set. It is never taken while `sts_nmi` is 1.
- R2: A maskable request (`req_nmi`=0) is taken only when `sts_pie` is 1 and `req_level` is strictly greater than `sts_il`, both compared as unsigned 6-bit values.
- R3: With `HAS_SHADOW`=1 (the default), a maskable request must also meet one of two conditions: `req_rset` differs from `sts_crs`, or `sts_rsie` is 1.
- R4: After a request is taken, `sts_pie` becomes 0 when `cfg_ani` is 0. When `cfg_ani` is 1, `sts_pie` keeps its previous value.
- R5: On the edge after a take, the `est_*` outputs hold the values that `sts_pie`, `sts_il`, `sts_crs`, `sts_rsie` and `sts_nmi` had before that edge. In every other cycle, `est_*` does not change.
- R6: On the edge after a take, `sts_il` is loaded with `req_level` and `sts_crs` with `req_rset`, and `sts_rsie` keeps its value. `sts_nmi` becomes 1 for a non-maskable request and keeps its value for a maskable one.
- R7: `take` is combinational from the inputs and the current status. It is 0 whenever `req_valid` is 0. `handler_addr` equals `req_handler` while `take` is 1 and is 0 otherwise.
- R8: When `eret` is 1, `take` is 0. On the next edge, the status outputs, including `sts_nmi`, are reloaded from the `est_*` values.
- R9: `sts_wr_en`=1 loads `sts_pie`, `sts_il`, `sts_crs` and `sts_rsie` from the `sts_wr_*` inputs and leaves `sts_nmi` unchanged. The write is ignored in a cycle where `take` or `eret` is 1.
- R10: After reset, every status and saved-status output is 0, the context is `CTX_NORMAL`, and `take` is 0 for any maskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered by the interrupt controller |
| req_nmi | input | 1 | Request is non-maskable |
| req_level | input | 6 | Requested interrupt level |
| req_rset | input | 2 | Requested shadow register set |
| req_handler | input | ADDR_W | Requested handler address |
| cfg_ani | input | 1 | Auto-nesting: keep maskable interrupts enabled on take |
| eret | input | 1 | Exception return: restore the saved status |
| sts_wr_en | input | 1 | Software write to the status control register |
| sts_wr_pie | input | 1 | Write data: maskable enable |
| sts_wr_il | input | 6 | Write data: current level |
| sts_wr_crs | input | 2 | Write data: current register set |
| sts_wr_rsie | input | 1 | Write data: register-set interrupt enable |
| take | output | 1 | Request is taken this cycle |
| handler_addr | output | ADDR_W | Jump target while take is high, else 0 |
| sts_pie | output | 1 | Maskable interrupt enable |
| sts_il | output | 6 | Current interrupt level |
| sts_crs | output | 2 | Current register set |
| sts_rsie | output | 1 | Register-set interrupt enable |
| sts_nmi | output | 1 | Non-maskable handler in progress |
| est_pie | output | 1 | Saved maskable enable |
| est_il | output | 6 | Saved level |
| est_crs | output | 2 | Saved register set |
| est_rsie | output | 1 | Saved register-set interrupt enable |
| est_nmi | output | 1 | Saved non-maskable flag |

## Verification
Each acceptance rule is tested alone, with maskable requests that fail exactly one condition:
- enable off;
- level equal to the current level;
- same register set with `sts_rsie` clear.

Non-maskable requests are offered both with the enable off and during a running non-maskable handler. This separates the NMI rule from the maskable one. The same rising-level sequence is run twice, once with auto-nesting off and once with it on; only one of the two runs allows a second nested take, which shows the effect of the configuration. Exception returns and status writes are issued in the same cycle as a competing request, to confirm which action wins. The saved copy is compared on every cycle, so a stale or early capture shows up.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    // Width of the interrupt level field
    localparam int LVL_W = 6;
    // Width of a shadow register set number
    localparam int RS_W  = 2;

    // Handler context: is a non-maskable handler running
    typedef enum logic {
        CTX_NORMAL = 1'b0,
        CTX_NMI    = 1'b1
    } ctx_e;

    // Software-visible status fields, excluding the NMI flag
    typedef struct packed {
        logic             pie;
        logic [LVL_W-1:0] il;
        logic [RS_W-1:0]  crs;
        logic             rsie;
    } ctl_t;
endpackage

// File: rtl/irq_take_decide.sv
module irq_take_decide
    import irq_accept_pkg::*;
#(
    parameter bit HAS_SHADOW = 1'b1
) (
    input  logic             req_valid,
    input  logic             req_nmi,
    input  logic [LVL_W-1:0] req_level,
    input  logic [RS_W-1:0]  req_rset,
    input  ctl_t             cur,
    input  logic             nmi_busy,
    input  logic             eret,
    output logic             take
);
    logic lvl_ok;
    logic rs_ok;

    // Strict level comparison with the enable
    always_comb lvl_ok = cur.pie && (req_level > cur.il);

    // The register set conflict rule exists only with shadow sets
    generate
        if (HAS_SHADOW) begin : g_shadow
            always_comb rs_ok = (req_rset != cur.crs) || cur.rsie;
        end else begin : g_flat
            always_comb rs_ok = 1'b1;
        end
    endgenerate

    always_comb begin
        if (!req_valid || eret)
            take = 1'b0;
        else if (req_nmi)
            take = !nmi_busy;
        else
            take = lvl_ok && rs_ok;
    end
endmodule

// File: rtl/irq_ctx_fsm.sv
module irq_ctx_fsm
    import irq_accept_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             req_nmi,
    input  logic [LVL_W-1:0] req_level,
    input  logic [RS_W-1:0]  req_rset,
    input  logic             cfg_ani,
    input  logic             eret,
    input  ctl_t             saved_ctl,
    input  logic             saved_nmi,
    input  logic             wr_en,
    input  ctl_t             wr_ctl,
    output ctl_t             cur_ctl,
    output ctx_e             state
);
    ctx_e state_nx;
    ctl_t ctl_nx;

    // Next context
    always_comb begin
        state_nx = state;
        unique case (state)
            CTX_NORMAL: begin
                if (eret)
                    state_nx = saved_nmi ? CTX_NMI : CTX_NORMAL;
                else if (take && req_nmi)
                    state_nx = CTX_NMI;               // T_TAKE_NMI
            end
            CTX_NMI: begin
                if (eret)
                    state_nx = saved_nmi ? CTX_NMI : CTX_NORMAL; // T_RETURN
            end
            default: state_nx = CTX_NORMAL;
        endcase
    end

    // Next status fields: take, then return, then software write
    always_comb begin
        ctl_nx = cur_ctl;
        if (take) begin
            ctl_nx.pie = cfg_ani & cur_ctl.pie;
            ctl_nx.il  = req_level;
            ctl_nx.crs = req_rset;
        end else if (eret) begin
            ctl_nx = saved_ctl;
        end else if (wr_en) begin
            ctl_nx = wr_ctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CTX_NORMAL;
            cur_ctl <= '0;
        end else begin
            state   <= state_nx;
            cur_ctl <= ctl_nx;
        end
    end
endmodule

// File: rtl/irq_saved_status.sv
module irq_saved_status
    import irq_accept_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  ctl_t cur_ctl,
    input  logic cur_nmi,
    output ctl_t saved_ctl,
    output logic saved_nmi
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            saved_ctl <= '0;
            saved_nmi <= 1'b0;
        end else if (take) begin
            saved_ctl <= cur_ctl;
            saved_nmi <= cur_nmi;
        end
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
    import irq_accept_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter bit HAS_SHADOW = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_nmi,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [RS_W-1:0]   req_rset,
    input  logic [ADDR_W-1:0] req_handler,
    input  logic              cfg_ani,
    input  logic              eret,
    input  logic              sts_wr_en,
    input  logic              sts_wr_pie,
    input  logic [LVL_W-1:0]  sts_wr_il,
    input  logic [RS_W-1:0]   sts_wr_crs,
    input  logic              sts_wr_rsie,
    output logic              take,
    output logic [ADDR_W-1:0] handler_addr,
    output logic              sts_pie,
    output logic [LVL_W-1:0]  sts_il,
    output logic [RS_W-1:0]   sts_crs,
    output logic              sts_rsie,
    output logic              sts_nmi,
    output logic              est_pie,
    output logic [LVL_W-1:0]  est_il,
    output logic [RS_W-1:0]   est_crs,
    output logic              est_rsie,
    output logic              est_nmi
);
    ctl_t cur_ctl;
    ctl_t saved_ctl;
    ctl_t wr_ctl;
    ctx_e state;
    logic nmi_busy;
    logic saved_nmi;

    always_comb begin
        wr_ctl.pie  = sts_wr_pie;
        wr_ctl.il   = sts_wr_il;
        wr_ctl.crs  = sts_wr_crs;
        wr_ctl.rsie = sts_wr_rsie;
    end

    assign nmi_busy = (state == CTX_NMI);

    irq_take_decide #(.HAS_SHADOW(HAS_SHADOW)) u_decide (
        .req_valid (req_valid),
        .req_nmi   (req_nmi),
        .req_level (req_level),
        .req_rset  (req_rset),
        .cur       (cur_ctl),
        .nmi_busy  (nmi_busy),
        .eret      (eret),
        .take      (take)
    );

    irq_ctx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .req_nmi   (req_nmi),
        .req_level (req_level),
        .req_rset  (req_rset),
        .cfg_ani   (cfg_ani),
        .eret      (eret),
        .saved_ctl (saved_ctl),
        .saved_nmi (saved_nmi),
        .wr_en     (sts_wr_en),
        .wr_ctl    (wr_ctl),
        .cur_ctl   (cur_ctl),
        .state     (state)
    );

    irq_saved_status u_saved (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .cur_ctl   (cur_ctl),
        .cur_nmi   (nmi_busy),
        .saved_ctl (saved_ctl),
        .saved_nmi (saved_nmi)
    );

    assign handler_addr = take ? req_handler : '0;

    assign sts_pie  = cur_ctl.pie;
    assign sts_il   = cur_ctl.il;
    assign sts_crs  = cur_ctl.crs;
    assign sts_rsie = cur_ctl.rsie;
    assign sts_nmi  = nmi_busy;
    assign est_pie  = saved_ctl.pie;
    assign est_il   = saved_ctl.il;
    assign est_crs  = saved_ctl.crs;
    assign est_rsie = saved_ctl.rsie;
    assign est_nmi  = saved_nmi;

    // R1: a non-maskable take never happens inside a non-maskable handler
    a_r1_nmi_not_reentered: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_nmi) |-> !sts_nmi);

    // R2: a maskable take needs the enable and a strictly higher level
    a_r2_mask_level: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !req_nmi) |-> (sts_pie && (req_level > sts_il)));

    // R5: the saved copy holds the status from before the take
    a_r5_saved_copy: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (est_il == $past(sts_il)) && (est_nmi == $past(sts_nmi)));

    // R6: level and register set follow the request
    a_r6_level_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (sts_il == $past(req_level)) && (sts_crs == $past(req_rset)));

    // R6: taking a non-maskable request marks the handler as running
    a_r6_nmi_set: assert property (@(posedge clk) disable iff (!rst_n)
        (take && req_nmi) |=> sts_nmi);

    // R8: no take in a return cycle
    a_r8_eret_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        eret |-> !take);

    // R4: the enable is cleared without auto-nesting
    a_r4_pie_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cfg_ani) |=> !sts_pie);
endmodule

// File: tb/sim_irq_accept_unit.sv
module sim_irq_accept_unit;
    import irq_accept_pkg::*;

    localparam int AW = 32;
    localparam int VW = 1 + AW + 2 * (3 + LVL_W + RS_W);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic              req_valid, req_nmi, cfg_ani, eret;
    logic [LVL_W-1:0]  req_level;
    logic [RS_W-1:0]   req_rset;
    logic [AW-1:0]     req_handler;
    logic              sts_wr_en, sts_wr_pie, sts_wr_rsie;
    logic [LVL_W-1:0]  sts_wr_il;
    logic [RS_W-1:0]   sts_wr_crs;
    logic              take;
    logic [AW-1:0]     handler_addr;
    logic              sts_pie, sts_rsie, sts_nmi, est_pie, est_rsie, est_nmi;
    logic [LVL_W-1:0]  sts_il, est_il;
    logic [RS_W-1:0]   sts_crs, est_crs;

    irq_accept_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_nmi(req_nmi), .req_level(req_level),
        .req_rset(req_rset), .req_handler(req_handler), .cfg_ani(cfg_ani),
        .eret(eret), .sts_wr_en(sts_wr_en), .sts_wr_pie(sts_wr_pie),
        .sts_wr_il(sts_wr_il), .sts_wr_crs(sts_wr_crs), .sts_wr_rsie(sts_wr_rsie),
        .take(take), .handler_addr(handler_addr),
        .sts_pie(sts_pie), .sts_il(sts_il), .sts_crs(sts_crs),
        .sts_rsie(sts_rsie), .sts_nmi(sts_nmi),
        .est_pie(est_pie), .est_il(est_il), .est_crs(est_crs),
        .est_rsie(est_rsie), .est_nmi(est_nmi)
    );

    typedef struct {
        logic [VW-1:0] v;
        string         tag;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference status built from the requirements
    logic             m_pie, m_rsie, m_nmi, e_pie, e_rsie, e_nmi;
    logic [LVL_W-1:0] m_il, e_il;
    logic [RS_W-1:0]  m_crs, e_crs;

    task automatic step(input string tag, input logic v, input logic n,
                        input logic [LVL_W-1:0] lvl, input logic [RS_W-1:0] rs,
                        input logic [AW-1:0] a, input logic ani, input logic er,
                        input logic wr, input logic wpie, input logic [LVL_W-1:0] wil,
                        input logic [RS_W-1:0] wcrs, input logic wrsie);
        logic tk;
        exp_t it;
        @(negedge clk);
        req_valid = v; req_nmi = n; req_level = lvl; req_rset = rs;
        req_handler = a; cfg_ani = ani; eret = er;
        sts_wr_en = wr; sts_wr_pie = wpie; sts_wr_il = wil;
        sts_wr_crs = wcrs; sts_wr_rsie = wrsie;
        // R1, R2, R3, R7, R8 acceptance
        tk = v && !er && (n ? !m_nmi
                            : (m_pie && (lvl > m_il) && ((rs != m_crs) || m_rsie)));
        if (tk) begin
            // R5 save, then R4 and R6 update
            e_pie = m_pie; e_il = m_il; e_crs = m_crs; e_rsie = m_rsie; e_nmi = m_nmi;
            m_pie = ani & m_pie; m_il = lvl; m_crs = rs; m_nmi = m_nmi | n;
        end else if (er) begin
            m_pie = e_pie; m_il = e_il; m_crs = e_crs; m_rsie = e_rsie; m_nmi = e_nmi;
        end else if (wr) begin
            m_pie = wpie; m_il = wil; m_crs = wcrs; m_rsie = wrsie;
        end
        it.v = {tk, (tk ? a : {AW{1'b0}}), m_pie, m_il, m_crs, m_rsie, m_nmi,
                e_pie, e_il, e_crs, e_rsie, e_nmi};
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: take sampled before the edge, status after it
    initial begin
        forever begin
            logic t;
            logic [AW-1:0] ha;
            logic [VW-1:0] obs;
            exp_t e;
            @(negedge clk);
            #3;
            t = take;
            ha = handler_addr;
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                obs = {t, ha, sts_pie, sts_il, sts_crs, sts_rsie, sts_nmi,
                       est_pie, est_il, est_crs, est_rsie, est_nmi};
                total++;
                if (obs !== e.v) begin
                    bad++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, obs, e.v);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        req_valid = 1'b1; req_nmi = 1'b0; req_level = 6'd9; req_rset = 2'd1;
        req_handler = 32'h100; cfg_ani = 1'b0; eret = 1'b0;
        sts_wr_en = 1'b0; sts_wr_pie = 1'b0; sts_wr_il = '0;
        sts_wr_crs = '0; sts_wr_rsie = 1'b0;
        {m_pie, m_il, m_crs, m_rsie, m_nmi} = '0;
        {e_pie, e_il, e_crs, e_rsie, e_nmi} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #2;
        // R10: reset state, maskable request refused
        total++;
        if ({take, sts_pie, sts_il, sts_crs, sts_rsie, sts_nmi,
             est_pie, est_il, est_crs, est_rsie, est_nmi} !== '0) begin
            bad++;
            $display("FAIL R10 reset: actual=%b%b%h%h%b%b expected=0",
                     take, sts_pie, sts_il, sts_crs, sts_rsie, sts_nmi);
        end
        rst_n = 1'b1;

        step("R2 enable off",        1,0, 6'd5, 2'd1, 32'h10,   0,0, 0,0,6'd0,2'd0,0);
        step("R9 status write",      0,0, 6'd0, 2'd0, 32'h0,    0,0, 1,1,6'd3,2'd0,0);
        step("R2 equal level",       1,0, 6'd3, 2'd1, 32'h20,   0,0, 0,0,6'd0,2'd0,0);
        step("R3 same set no rsie",  1,0, 6'd4, 2'd0, 32'h30,   0,0, 0,0,6'd0,2'd0,0);
        step("R6 maskable take",     1,0, 6'd4, 2'd1, 32'h1000, 0,0, 0,0,6'd0,2'd0,0);
        step("R4 enable cleared",    1,0, 6'd9, 2'd2, 32'h40,   0,0, 0,0,6'd0,2'd0,0);
        step("R1 nmi take",          1,1, 6'd10,2'd3, 32'h2000, 0,0, 0,0,6'd0,2'd0,0);
        step("R1 nmi busy",          1,1, 6'd11,2'd2, 32'h2100, 0,0, 0,0,6'd0,2'd0,0);
        step("R8 return from nmi",   0,0, 6'd0, 2'd0, 32'h0,    0,1, 0,0,6'd0,2'd0,0);
        step("R9 write rsie",        0,0, 6'd0, 2'd0, 32'h0,    0,0, 1,1,6'd0,2'd0,1);
        step("R4 auto-nest take",    1,0, 6'd2, 2'd0, 32'h3000, 1,0, 0,0,6'd0,2'd0,0);
        step("R4 nested take",       1,0, 6'd5, 2'd0, 32'h3100, 1,0, 0,0,6'd0,2'd0,0);
        step("R8 return beats req",  1,0, 6'd9, 2'd1, 32'h3200, 0,1, 0,0,6'd0,2'd0,0);
        step("R9 write vs take",     1,0, 6'd7, 2'd2, 32'h4000, 0,0, 1,1,6'd1,2'd3,0);
        step("R9 write vs return",   0,0, 6'd0, 2'd0, 32'h0,    0,1, 1,0,6'd8,2'd1,0);
        step("R7 no valid",          0,1, 6'd63,2'd3, 32'h5000, 0,0, 0,0,6'd0,2'd0,0);
        step("R5 nmi with enable",   1,1, 6'd1, 2'd2, 32'h6000, 1,0, 0,0,6'd0,2'd0,0);
        step("R7 idle after",        0,0, 6'd0, 2'd0, 32'h0,    0,0, 0,0,6'd0,2'd0,0);

        repeat (3) @(posedge clk);
        #2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule